// File: doc/BRIEF.md
# Load-Store Stall Cycle Counter

This block is a small profiling counter that measures how much extra time a processor spends in load/store unit operations. For every cycle in which an LSU operation is in progress, the count advances by one. The only exception is the opening cycle of each operation, which is flagged by a first-cycle marker and is never counted. As a result, a transfer that completes in two cycles adds one to the count, and one that needs four cycles adds three. A first-cycle flag is sampled on every cycle, so operations that follow each other with no idle cycle between them are still counted separately.

The count is 8 bits wide. Software sees it through a 32-bit register: reads return the count in the low byte and zeros above it, and writes load the low byte. When the count wraps from its maximum value back to zero, the block raises a one-cycle event pulse and keeps counting. An enable bit, taken from a control register, gates all counting. When that bit turns on, the count is cleared to zero.

Top module: `lsu_stall_counter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the register reads 0x00000000 and the event output is low.
- R2: With the enable high (and not just turned on), a cycle in which the busy input is 1 and the first-cycle flag is 0 raises the count by one at the next clock edge. A cycle with busy 0, or with busy 1 and first-cycle 1, leaves the count unchanged.
- R3: An operation of N busy cycles, whose first cycle is flagged, adds N-1 to the count: a 2-cycle operation adds 1 and a 4-cycle operation adds 3. This also holds when operations follow each other with no idle cycle.
- R4: A counted cycle taken at count 0xFF makes the count 0x00. The event output is 1 during exactly the one cycle in which the count first reads 0x00, and counting then continues from 0x00. Exactly one pulse occurs per 256 counted cycles.
- R5: While the enable is 0, the busy and first-cycle inputs have no effect on the count, and the event output stays 0.
- R6: In the cycle the enable goes from 0 to 1, the count is cleared to 0x00 at the next edge, whatever the busy input is doing. An enable that stays at 1 does not clear the count.
- R7: A register write (write strobe 1) loads write-data bits 7:0 into the count at the next edge. The write takes priority over both an increment and an enable-rise clear in the same cycle, and it is accepted even while the enable is 0.
- R8: Read-data bits 31:8 are always zero. Write-data bits 31:8 have no effect on the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_en_i | input | 1 | Enable bit from the control register; a 0-to-1 change clears the count |
| lsu_busy_i | input | 1 | An LSU operation is in progress this cycle |
| lsu_first_i | input | 1 | This cycle is the first cycle of an LSU operation |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data; only bits 7:0 are used |
| reg_rdata_o | output | 32 | Register read data: count in bits 7:0, zeros above |
| wrap_evt_o | output | 1 | One-cycle pulse when the count wraps to zero |

## Verification
The wrap event is the hardest behaviour to reach, because it needs 256 counted cycles unless a register write presets the count. The bench first writes 0xFE so it can look at the pulse edge in a short vector walk. It then writes zero and runs 256 uninterrupted counted cycles, checking that the pulse appears only on the last of them. The three ways the count can be updated (write, enable-rise clear and increment) are also driven together in a single cycle to confirm their priority.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    // Source chosen for the next count value, in priority order.
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_STEP  = 2'd1,
        UPD_CLEAR = 2'd2,
        UPD_LOAD  = 2'd3
    } lsc_upd_e;

endpackage

// File: rtl/lsc_enable_edge.sv
module lsc_enable_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic rise_o
);

    logic en_d, en_q;

    always_comb begin
        en_d = en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= en_d;
    end

    assign rise_o = en_i & ~en_q;

endmodule

// File: rtl/lsc_update_select.sv
module lsc_update_select
    import lsc_pkg::*;
(
    input  logic     wr_i,
    input  logic     en_rise_i,
    input  logic     en_i,
    input  logic     busy_i,
    input  logic     first_i,
    output lsc_upd_e upd_o
);

    logic stall_cycle;

    assign stall_cycle = en_i & busy_i & ~first_i;

    always_comb begin
        if (wr_i)             upd_o = UPD_LOAD;
        else if (en_rise_i)   upd_o = UPD_CLEAR;
        else if (stall_cycle) upd_o = UPD_STEP;
        else                  upd_o = UPD_HOLD;
    end

endmodule

// File: rtl/lsc_count_core.sv
module lsc_count_core
    import lsc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  lsc_upd_e         upd_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             wrap;
    } core_state_t;

    core_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.wrap = 1'b0;
        unique case (upd_i)
            UPD_LOAD:  state_d.count = load_val_i;
            UPD_CLEAR: state_d.count = '0;
            UPD_STEP: begin
                state_d.count = state_q.count + 1'b1;
                state_d.wrap  = (state_q.count == CNT_MAX);
            end
            default:   state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign count_o = state_q.count;
    assign wrap_o  = state_q.wrap;

endmodule

// File: rtl/lsu_stall_counter.sv
module lsu_stall_counter
    import lsc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int BUS_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             count_en_i,
    input  logic             lsu_busy_i,
    input  logic             lsu_first_i,
    input  logic             reg_wr_i,
    input  logic [BUS_W-1:0] reg_wdata_i,
    output logic [BUS_W-1:0] reg_rdata_o,
    output logic             wrap_evt_o
);

    localparam int PAD_W = BUS_W - CNT_W;

    logic             en_rise;
    lsc_upd_e         upd;
    logic [CNT_W-1:0] count;

    lsc_enable_edge i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (count_en_i),
        .rise_o (en_rise)
    );

    lsc_update_select i_sel (
        .wr_i      (reg_wr_i),
        .en_rise_i (en_rise),
        .en_i      (count_en_i),
        .busy_i    (lsu_busy_i),
        .first_i   (lsu_first_i),
        .upd_o     (upd)
    );

    lsc_count_core #(.CNT_W(CNT_W)) i_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .upd_i      (upd),
        .load_val_i (reg_wdata_i[CNT_W-1:0]),
        .count_o    (count),
        .wrap_o     (wrap_evt_o)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^reg_wdata_i[BUS_W-1:CNT_W];
            assign reg_rdata_o     = {{PAD_W{1'b0}}, count};
        end else begin : g_nopad
            assign reg_rdata_o = count;
        end
    endgenerate

endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
    parameter int CNT_W = 8,
    parameter int BUS_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             count_en_i,
    input logic             lsu_busy_i,
    input logic             lsu_first_i,
    input logic             reg_wr_i,
    input logic [BUS_W-1:0] reg_wdata_i,
    input logic [BUS_W-1:0] reg_rdata_o,
    input logic             wrap_evt_o
);

    logic en_seen_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wd;
    logic unused_hi;

    assign cnt       = reg_rdata_o[CNT_W-1:0];
    assign wd        = reg_wdata_i[CNT_W-1:0];
    assign unused_hi = ^reg_wdata_i[BUS_W-1:CNT_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_seen_q <= 1'b0;
        else         en_seen_q <= count_en_i;
    end

    assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_en_i && en_seen_q && lsu_busy_i && !lsu_first_i && !reg_wr_i)
        |=> cnt == CNT_W'($past(cnt) + 1'b1));

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!reg_wr_i && !(count_en_i && !en_seen_q) && !(lsu_busy_i && !lsu_first_i))
        |=> $stable(cnt));

    assert_wrap_prev_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_evt_o |-> (cnt == '0 && $past(cnt) == {CNT_W{1'b1}}));

    assert_wrap_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_evt_o |=> !wrap_evt_o);

    assert_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!count_en_i && !reg_wr_i) |=> ($stable(cnt) && !wrap_evt_o));

    assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_en_i && !en_seen_q && !reg_wr_i) |=> cnt == '0);

    assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_wr_i |=> cnt == $past(wd));

    assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[BUS_W-1:CNT_W] == '0);

endmodule

bind lsu_stall_counter lsc_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_lsc_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_en_i  (count_en_i),
    .lsu_busy_i  (lsu_busy_i),
    .lsu_first_i (lsu_first_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .wrap_evt_o  (wrap_evt_o)
);

// File: tb/test_lsu_stall_counter.sv
module test_lsu_stall_counter;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        count_en_i = 1'b0;
    logic        lsu_busy_i = 1'b0;
    logic        lsu_first_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        wrap_evt_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk_i = ~clk_i;

    lsu_stall_counter i_lsu_stall_counter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .count_en_i  (count_en_i),
        .lsu_busy_i  (lsu_busy_i),
        .lsu_first_i (lsu_first_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .wrap_evt_o  (wrap_evt_o)
    );

    // Vector: {en, busy, first, wr, wdata[7:0], expected count, expected event}
    localparam int NV = 21;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {4'b1000, 8'h00, 8'h00, 1'b0},  // enable rises: clear (R6)
        {4'b1110, 8'h00, 8'h00, 1'b0},  // first cycle skipped (R2)
        {4'b1100, 8'h00, 8'h01, 1'b0},  // 2-cycle op adds 1 (R3)
        {4'b1110, 8'h00, 8'h01, 1'b0},  // back-to-back new op (R3)
        {4'b1100, 8'h00, 8'h02, 1'b0},
        {4'b1100, 8'h00, 8'h03, 1'b0},
        {4'b1100, 8'h00, 8'h04, 1'b0},  // 4-cycle op adds 3 (R3)
        {4'b1000, 8'h00, 8'h04, 1'b0},  // idle holds (R2)
        {4'b0100, 8'h00, 8'h04, 1'b0},  // disabled ignores busy (R5)
        {4'b0001, 8'h37, 8'h37, 1'b0},  // write while disabled (R7)
        {4'b1100, 8'h00, 8'h00, 1'b0},  // rise clears over step (R6)
        {4'b1101, 8'hA0, 8'hA0, 1'b0},  // write beats step (R7)
        {4'b1100, 8'h00, 8'hA1, 1'b0},
        {4'b0001, 8'h10, 8'h10, 1'b0},
        {4'b1001, 8'h55, 8'h55, 1'b0},  // write beats rise clear (R7)
        {4'b1100, 8'h00, 8'h56, 1'b0},  // steady enable no clear (R6)
        {4'b1001, 8'hFE, 8'hFE, 1'b0},
        {4'b1100, 8'h00, 8'hFF, 1'b0},
        {4'b1100, 8'h00, 8'h00, 1'b1},  // wrap pulse (R4)
        {4'b1100, 8'h00, 8'h01, 1'b0},  // keeps counting, pulse gone (R4)
        {4'b1000, 8'h00, 8'h01, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic busy, input logic first,
                        input logic wr, input logic [31:0] wd);
        count_en_i  = en;
        lsu_busy_i  = busy;
        lsu_first_i = first;
        reg_wr_i    = wr;
        reg_wdata_i = wd;
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk_i);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int evt_cnt;
        int evt_at;
        repeat (3) @(negedge clk_i);
        check("R1 rdata in reset", reg_rdata_o, 32'h0);
        check("R1 event in reset", {31'b0, wrap_evt_o}, 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 rdata after reset", reg_rdata_o, 32'h0);
        check("R1 event after reset", {31'b0, wrap_evt_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            step(v[20], v[19], v[18], v[17], {24'hFFFFFF, v[16:9]});
            check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d count", i), reg_rdata_o, {24'h0, v[8:1]});
            check($sformatf("R4 vector %0d event", i), {31'b0, wrap_evt_o}, {31'b0, v[0]});
        end

        // R8: upper write bits ignored, upper read bits zero
        step(1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
        check("R8 all-ones write", reg_rdata_o, 32'h0000_00FF);

        // R4: full 256-cycle run from zero, one pulse at the end
        step(1'b1, 1'b0, 1'b0, 1'b1, 32'h0);
        evt_cnt = 0;
        evt_at  = -1;
        for (int i = 0; i < 256; i++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
            if (wrap_evt_o) begin
                evt_cnt++;
                evt_at = i;
            end
        end
        check("R4 pulses per 256 cycles", evt_cnt, 1);
        check("R4 pulse position", evt_at, 255);
        check("R4 count after full run", reg_rdata_o, 32'h0);

        // R5: disabled, heavy busy traffic, nothing moves
        step(1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_00FF);
        evt_cnt = 0;
        for (int i = 0; i < 12; i++) begin
            step(1'b0, 1'b1, i[0], 1'b0, 32'h0);
            if (wrap_evt_o) evt_cnt++;
        end
        check("R5 count held while disabled", reg_rdata_o, 32'h0000_00FF);
        check("R5 no event while disabled", evt_cnt, 0);

        // R3: two back-to-back 2-cycle ops after re-enable
        step(1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'h0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
        step(1'b1, 1'b1, 1'b1, 1'b0, 32'h0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
        check("R3 two back-to-back ops", reg_rdata_o, 32'h2);

        // R1: reset in mid-run
        count_en_i = 1'b1;
        lsu_busy_i = 1'b1;
        lsu_first_i = 1'b0;
        reg_wr_i = 1'b0;
        #3 rst_ni = 1'b0;
        #2;
        check("R1 async reset clears", reg_rdata_o, 32'h0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 idle after reset release", reg_rdata_o, 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule